// File: doc/BRIEF.md
# Transmit Event Latch with Clock-Loss Monitor

This block gathers the event pulses of one transmit port into an 8-bit sticky status register and drives an active-low interrupt from it. The elastic store, the framer and the multiframe counters send single-cycle pulses for these events: frame repeat (store empty), frame delete (store full), any slip, a 72-frame multiframe boundary, a pulse-density violation and a regular multiframe boundary. Each pulse sets its own bit, and the bit stays set until the host clears it.

The block also watches the transmit clock against the faster system clock. When the transmit clock stops toggling for a set number of system cycles, a loss fault is declared. A dedicated output pin follows the live fault. One sticky bit records the start of the fault and another records its end. The host reads the register, clears bits by writing ones, and picks through an 8-bit mask which bits may pull the interrupt low.

Top module: `tx_evt_latch`

## Requirements
- R1: After reset, `stat_q` and `mask_q` are 0, `irq_n` is 1 and `loc_pin` is 0.
- R2: A one-cycle pulse on an event input sets its bit of `stat_q` one clock later. The bit positions are full=7, empty=6, slip=5, 72-frame=4, density=3, multiframe=2. A set bit stays set after the pulse ends until the host clears it.
- R3: A pulse on `ev_empty` or `ev_full` also sets bit 5 (slip).
- R4: A clock edge with `clr_we` high clears every bit of `stat_q` whose `clr_data` bit is 1 and leaves the bits under 0 unchanged. If a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R5: When the transmit clock shows no transition for `TX_PERIOD_CYC*LOSS_PERIODS` system cycles, a loss fault is declared. Bit 0 sets at the onset, and `loc_pin` goes high while `loc_en` is 1.
- R6: Clearing bit 0 during a fault leaves it at 0 for the rest of that fault. `loc_pin` stays high for as long as the fault lasts.
- R7: When transmit clock transitions return, the fault ends, `loc_pin` falls and bit 1 sets.
- R8: With `loc_en` at 0, `loc_pin` stays 0 and bit 0 still latches on a fault.
- R9: `irq_n` is 0 exactly when some bit is 1 in both `stat_q` and `mask_q`.
- R10: A clock edge with `mask_we` high loads `mask_data` into `mask_q`. A mask bit of 1 lets that status bit assert the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| tx_clk | input | 1 | monitored transmit clock (asynchronous) |
| loc_en | input | 1 | enable for the loss pin |
| ev_mf | input | 1 | multiframe boundary pulse |
| ev_pdv | input | 1 | pulse-density violation pulse |
| ev_slc | input | 1 | 72-frame multiframe pulse |
| ev_slip | input | 1 | elastic-store slip pulse |
| ev_empty | input | 1 | store empty / frame repeated pulse |
| ev_full | input | 1 | store full / frame deleted pulse |
| clr_we | input | 1 | clear strobe |
| clr_data | input | 8 | write-one-to-clear bit pattern |
| mask_we | input | 1 | mask write strobe |
| mask_data | input | 8 | new interrupt mask |
| stat_q | output | 8 | latched status |
| mask_q | output | 8 | current interrupt mask |
| irq_n | output | 1 | interrupt, active low |
| loc_pin | output | 1 | live loss-of-clock indication |

## Verification
The assertions assume that the event inputs are synchronous to `clk`. They also assume that `tx_clk`, when it runs, toggles well within the terminal count, so a running clock never trips the detector. The bench drives every input on the falling system edge and divides the system clock by eight to make the transmit clock. It stops that divider only in the directed loss phases. During the random phase the transmit clock runs, so the two loss bits stay at zero and the bench model can track the other six exactly.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int NB = 8;
  localparam int B_LOC  = 0;
  localparam int B_LOCC = 1;
  localparam int B_MF   = 2;
  localparam int B_PDV  = 3;
  localparam int B_SLC  = 4;
  localparam int B_SLIP = 5;
  localparam int B_EMP  = 6;
  localparam int B_FULL = 7;

  typedef logic [NB-1:0] stat_t;

  // Map event pulses onto status positions; empty/full also imply a slip.
  function automatic stat_t set_vector(input logic mf, input logic pdv,
                                       input logic slc, input logic slip,
                                       input logic emp, input logic full,
                                       input logic l_on, input logic l_off);
    stat_t v;
    v         = '0;
    v[B_LOC]  = l_on;
    v[B_LOCC] = l_off;
    v[B_MF]   = mf;
    v[B_PDV]  = pdv;
    v[B_SLC]  = slc;
    v[B_SLIP] = slip | emp | full;
    v[B_EMP]  = emp;
    v[B_FULL] = full;
    return v;
  endfunction

  // Write-one-to-clear, set has priority.
  function automatic stat_t next_status(input stat_t q, input stat_t setv,
                                        input logic clr_we, input stat_t clr);
    stat_t keep;
    keep = clr_we ? ~clr : '1;
    return (q & keep) | setv;
  endfunction

  function automatic logic irq_active(input stat_t q, input stat_t m);
    return |(q & m);
  endfunction
endpackage

// File: rtl/txs_clk_loss.sv
module txs_clk_loss #(
  parameter int TX_PERIOD_CYC = 8,
  parameter int LOSS_PERIODS  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_clk,
  output logic loss,
  output logic loss_rise,
  output logic loss_fall
);
  localparam int TERM = TX_PERIOD_CYC * LOSS_PERIODS;
  localparam int CW   = $clog2(TERM + 1);

  logic          s1, s2, s3;
  logic [CW-1:0] cnt;
  logic          loss_d;
  logic          tx_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tx_clk;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign tx_edge = s2 ^ s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (tx_edge)            cnt <= '0;
    else if (cnt != CW'(TERM))   cnt <= cnt + 1'b1;
  end

  assign loss = (cnt == CW'(TERM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loss_d <= 1'b0;
    else        loss_d <= loss;
  end

  assign loss_rise = loss & ~loss_d;
  assign loss_fall = ~loss & loss_d;

  // R5: a seen edge always ends the fault
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_edge |=> !loss);
  // R5: onset only after a quiet cycle
  p_quiet_onset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loss) |-> !$past(tx_edge));
endmodule

// File: rtl/txs_stat_reg.sv
module txs_stat_reg
  import txs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t set_v,
  input  logic  clr_we,
  input  stat_t clr_v,
  input  logic  mask_we,
  input  stat_t mask_v,
  output stat_t stat_q,
  output stat_t mask_q,
  output logic  irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= next_status(stat_q, set_v, clr_we, clr_v);
      if (mask_we) mask_q <= mask_v;
    end
  end

  assign irq_n = ~irq_active(stat_q, mask_q);

  for (genvar i = 0; i < NB; i++) begin : g_bit
    // R4: set wins over a same-cycle clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> stat_q[i]);
    // R2: bit is sticky without a clear
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !(clr_we && clr_v[i])) |=> stat_q[i]);
  end

  // R9: only a clear or a mask write can release the interrupt
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !clr_we && !mask_we) |=> !irq_n);
endmodule

// File: rtl/tx_evt_latch.sv
module tx_evt_latch
  import txs_pkg::*;
#(
  parameter int TX_PERIOD_CYC = 8,
  parameter int LOSS_PERIODS  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_clk,
  input  logic       loc_en,
  input  logic       ev_mf,
  input  logic       ev_pdv,
  input  logic       ev_slc,
  input  logic       ev_slip,
  input  logic       ev_empty,
  input  logic       ev_full,
  input  logic       clr_we,
  input  logic [7:0] clr_data,
  input  logic       mask_we,
  input  logic [7:0] mask_data,
  output logic [7:0] stat_q,
  output logic [7:0] mask_q,
  output logic       irq_n,
  output logic       loc_pin
);
  logic  loss, loss_rise, loss_fall;
  stat_t set_v;

  txs_clk_loss #(.TX_PERIOD_CYC(TX_PERIOD_CYC), .LOSS_PERIODS(LOSS_PERIODS)) u_det (
    .clk(clk), .rst_n(rst_n), .tx_clk(tx_clk),
    .loss(loss), .loss_rise(loss_rise), .loss_fall(loss_fall)
  );

  assign set_v = set_vector(ev_mf, ev_pdv, ev_slc, ev_slip, ev_empty, ev_full,
                            loss_rise, loss_fall);

  txs_stat_reg u_reg (
    .clk(clk), .rst_n(rst_n), .set_v(set_v),
    .clr_we(clr_we), .clr_v(clr_data),
    .mask_we(mask_we), .mask_v(mask_data),
    .stat_q(stat_q), .mask_q(mask_q), .irq_n(irq_n)
  );

  assign loc_pin = loss & loc_en;

  // R3: frame repeat or delete always records a slip
  p_slip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_empty || ev_full) |=> stat_q[B_SLIP]);
  // R7: end of fault records the cleared bit
  p_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(loss) |=> stat_q[B_LOCC]);
endmodule

// File: tb/sim_tx_evt_latch.sv
module sim_tx_evt_latch;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, tx_clk = 0, tx_run = 0, loc_en = 0;
  logic ev_mf = 0, ev_pdv = 0, ev_slc = 0, ev_slip = 0, ev_empty = 0, ev_full = 0;
  logic clr_we = 0, mask_we = 0;
  logic [7:0] clr_data = 0, mask_data = 0;
  logic [7:0] stat_q, mask_q;
  logic irq_n, loc_pin;
  logic [1:0] div = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m_stat, m_mask;

  tx_evt_latch u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  always @(negedge clk) if (tx_run) begin
    div <= div + 2'd1;
    if (div == 2'd3) tx_clk <= ~tx_clk;
  end

  function automatic logic [7:0] ev_bits(logic f, logic e, logic s, logic c, logic p, logic m);
    return {f, e, s | e | f, c, p, m, 2'b00};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    {ev_mf, ev_pdv, ev_slc, ev_slip, ev_empty, ev_full} = '0;
    clr_we = 0; mask_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    tx_run = 1; loc_en = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stat_q, 8'h00, "R1"); chk(mask_q, 8'h00, "R1");
    chk({7'd0, irq_n}, 8'h01, "R1"); chk({7'd0, loc_pin}, 8'h00, "R1");
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk(stat_q, 8'h00, "R1");

    // R5 loss onset
    tx_run = 0;
    repeat (40) @(negedge clk);
    chk({7'd0, loc_pin}, 8'h01, "R5");
    chk(stat_q, 8'h01, "R5");
    chk({7'd0, irq_n}, 8'h01, "R9");
    mask_we = 1; mask_data = 8'h01;
    @(negedge clk); idle();
    chk(mask_q, 8'h01, "R10"); chk({7'd0, irq_n}, 8'h00, "R9");
    // R6 clear during fault
    clr_we = 1; clr_data = 8'h01;
    @(negedge clk); idle();
    chk(stat_q, 8'h00, "R6"); chk({7'd0, irq_n}, 8'h01, "R9");
    repeat (10) @(negedge clk);
    chk(stat_q, 8'h00, "R6"); chk({7'd0, loc_pin}, 8'h01, "R6");
    // R7 clock returns
    tx_run = 1;
    repeat (20) @(negedge clk);
    chk({7'd0, loc_pin}, 8'h00, "R7"); chk(stat_q, 8'h02, "R7");
    // R8 pin disabled
    loc_en = 0; tx_run = 0;
    repeat (40) @(negedge clk);
    chk({7'd0, loc_pin}, 8'h00, "R8"); chk(stat_q & 8'h01, 8'h01, "R8");
    tx_run = 1;
    repeat (20) @(negedge clk);
    loc_en = 1;
    clr_we = 1; clr_data = 8'hFF; mask_we = 1; mask_data = 8'h00;
    @(negedge clk); idle();
    chk(stat_q, 8'h00, "R4");

    // R3 empty implies slip
    ev_empty = 1;
    @(negedge clk); idle();
    chk(stat_q, 8'h60, "R3");
    // R2 sticky after pulse
    repeat (3) @(negedge clk);
    chk(stat_q, 8'h60, "R2");
    // R4 zero bits keep, one bits clear
    clr_we = 1; clr_data = 8'h40;
    @(negedge clk); idle();
    chk(stat_q, 8'h20, "R4");
    // R4 set wins on same-cycle clear
    ev_mf = 1; clr_we = 1; clr_data = 8'h24;
    @(negedge clk); idle();
    chk(stat_q, 8'h04, "R4");
    clr_we = 1; clr_data = 8'hFF;
    @(negedge clk); idle();

    // random phase, transmit clock running
    m_stat = 8'h00; m_mask = 8'h00;
    for (int i = 0; i < 3000; i++) begin
      chk(stat_q, m_stat, "R2");
      chk(mask_q, m_mask, "R10");
      chk({7'd0, irq_n}, {7'd0, ~|(m_stat & m_mask)}, "R9");
      ev_mf    = ($urandom % 8) == 0; ev_pdv  = ($urandom % 8) == 0;
      ev_slc   = ($urandom % 8) == 0; ev_slip = ($urandom % 8) == 0;
      ev_empty = ($urandom % 8) == 0; ev_full = ($urandom % 8) == 0;
      clr_we   = ($urandom % 4) == 0; clr_data  = 8'($urandom);
      mask_we  = ($urandom % 6) == 0; mask_data = 8'($urandom);
      m_stat = (m_stat & (clr_we ? ~clr_data : 8'hFF)) |
               ev_bits(ev_full, ev_empty, ev_slip, ev_slc, ev_pdv, ev_mf);
      if (mask_we) m_mask = mask_data;
      @(negedge clk);
      idle();
    end
    chk(stat_q, m_stat, "R2");
    finish_run();
  end
endmodule